// File: doc/BRIEF.md
# Two-Channel Light Sensor Register Core

This block holds the command and data registers of a two-channel logarithmic light-sensor slave. A byte-level bus front end, outside this block, presents written command bytes with a write strobe. It raises a read strobe when it needs a return byte. The core decodes six fixed command codes. These codes control the power state and the dynamic range mode. They also choose which register the next reads return: the command register, channel 0 or channel 1.

Each channel register holds a 7-bit compressed result, split into a 3-bit chord and a 4-bit step, plus a valid flag. The converter side supplies per-channel results with a strobe. The core accepts them only while powered up. The power state and range mode are driven out so they can steer the converter. Read data is registered and returned one cycle after the read strobe. It reflects the state as it stood before any write or capture made in that same cycle.

Top module: `lsens_regs`

## Requirements
- R1: After a synchronous active-low reset, `powered` and `ext_range` are 0, and a read returns 0x00, the command register value.
- R2: Writing 0x03 sets `powered` and points reads at the command register, so the next read returns 0x03.
- R3: While powered up, writing 0x1D sets `ext_range` and writing 0x18 clears it. While powered down, both codes are ignored.
- R4: The range mode stays in place across the select commands and a repeated 0x03.
- R5: Writing 0x00 clears `powered`, `ext_range` and both valid flags, and points reads at the command register, which becomes 0x00. Stored data bits are kept.
- R6: Writing 0x43 or 0x83 makes later reads return channel 0 or channel 1. The returned byte carries the valid flag in bit 7, the chord in bits 6:4 and the step in bits 3:0.
- R7: While powered up, a result strobe for a channel loads its 7 data bits and sets its valid flag on the same edge. The values 0x00 (below detection) and 0x7F (overflow) are stored unchanged.
- R8: Result strobes that arrive while powered down leave both channel registers unchanged.
- R9: A written byte other than the six codes leaves the power state, range mode, read selection and command register unchanged.
- R10: `rd_valid` pulses one cycle after `rd_en`, and `rd_data` then holds the selected register value from before that edge. A write or capture in the same cycle does not affect it.
- R11: A 0x00 write in the same cycle as a result strobe wins: nothing is captured and both valid flags end cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command byte write strobe |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Returned byte, valid while rd_valid is high |
| rd_valid | output | 1 | Return byte available, one cycle after rd_en |
| conv_strobe | input | 2 | Per-channel result strobe, bit n for channel n |
| conv_data0 | input | 7 | Channel 0 result, chord 6:4, step 3:0 |
| conv_data1 | input | 7 | Channel 1 result, chord 6:4, step 3:0 |
| powered | output | 1 | Device powered up |
| ext_range | output | 1 | Extended range mode selected |

## Verification
A converter result strobe can land in the same cycle as a power-down command. It can also land in the same cycle as a read of the channel it updates. The bench drives the strobe together with a 0x00 write. It then re-selects the channel and expects the old data with the valid flag clear. The bench also fires a strobe and a read strobe together. It expects the pre-capture byte back, then the new byte on the following read. The same-cycle write-with-read case is judged in the same way.

// File: rtl/lsens_regs.sv
module lsens_regs #(
  parameter int RES_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [RES_W:0]   rd_data,
  output logic             rd_valid,
  input  logic [1:0]       conv_strobe,
  input  logic [RES_W-1:0] conv_data0,
  input  logic [RES_W-1:0] conv_data1,
  output logic             powered,
  output logic             ext_range
);
  localparam logic [7:0] C_DOWN = 8'h00;
  localparam logic [7:0] C_UP   = 8'h03;
  localparam logic [7:0] C_EXT  = 8'h1D;
  localparam logic [7:0] C_STD  = 8'h18;
  localparam logic [7:0] C_CH0  = 8'h43;
  localparam logic [7:0] C_CH1  = 8'h83;

  typedef enum logic [1:0] {SEL_CMD, SEL_CH0, SEL_CH1} sel_t;

  sel_t             sel;
  logic [7:0]       cmd_reg;
  logic [RES_W-1:0] d0, d1;
  logic             v0, v1;
  logic [RES_W:0]   rd_mux;

  wire is_down = wr_en && (wr_data == C_DOWN);
  wire is_up   = wr_en && (wr_data == C_UP);
  wire is_rng  = wr_en && powered && ((wr_data == C_EXT) || (wr_data == C_STD));
  wire is_ch0  = wr_en && (wr_data == C_CH0);
  wire is_ch1  = wr_en && (wr_data == C_CH1);
  wire known   = (wr_data == C_DOWN) || (wr_data == C_UP) || (wr_data == C_EXT) ||
                 (wr_data == C_STD) || (wr_data == C_CH0) || (wr_data == C_CH1);
  wire cap0    = powered && conv_strobe[0] && !is_down;
  wire cap1    = powered && conv_strobe[1] && !is_down;

  always_comb begin
    case (sel)
      SEL_CH0: rd_mux = {v0, d0};
      SEL_CH1: rd_mux = {v1, d1};
      default: rd_mux = cmd_reg[RES_W:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      powered   <= 1'b0;
      ext_range <= 1'b0;
      sel       <= SEL_CMD;
      cmd_reg   <= C_DOWN;
      d0        <= '0;
      d1        <= '0;
      v0        <= 1'b0;
      v1        <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (cap0) begin d0 <= conv_data0; v0 <= 1'b1; end
      if (cap1) begin d1 <= conv_data1; v1 <= 1'b1; end
      if (is_down) begin
        powered   <= 1'b0;
        ext_range <= 1'b0;
        v0        <= 1'b0;
        v1        <= 1'b0;
        sel       <= SEL_CMD;
        cmd_reg   <= C_DOWN;
      end
      if (is_up) begin
        powered <= 1'b1;
        sel     <= SEL_CMD;
        cmd_reg <= C_UP;
      end
      if (is_rng) begin
        ext_range <= (wr_data == C_EXT);
        cmd_reg   <= wr_data;
      end
      if (is_ch0) begin sel <= SEL_CH0; cmd_reg <= wr_data; end
      if (is_ch1) begin sel <= SEL_CH1; cmd_reg <= wr_data; end
    end
  end

  p_ext_needs_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_range |-> powered);

  p_down_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_down |=> (!powered && !ext_range && !v0 && !v1 && sel == SEL_CMD));

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap0 |=> (v0 && d0 == $past(conv_data0)));

  p_down_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |=> ($stable(d0) && $stable(d1)));

  p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !known) |=> ($stable(powered) && $stable(ext_range) &&
                           $stable(sel) && $stable(cmd_reg)));

  p_rdv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  p_down_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_down && conv_strobe != 2'b00) |=> (!v0 && !v1));
endmodule

// File: tb/test_lsens_regs.sv
module test_lsens_regs;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [1:0] conv_strobe = '0;
  logic [6:0] conv_data0 = '0;
  logic [6:0] conv_data1 = '0;
  logic       powered, ext_range;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_T/2) clk = ~clk;

  lsens_regs i_lsens_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .conv_strobe(conv_strobe), .conv_data0(conv_data0), .conv_data1(conv_data1),
    .powered(powered), .ext_range(ext_range)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] wd, input bit r,
                      input logic [7:0] rexp, input string tag,
                      input logic [1:0] st, input logic [6:0] a, input logic [6:0] b);
    wr_en = w; wr_data = wd; rd_en = r;
    conv_strobe = st; conv_data0 = a; conv_data1 = b;
    if (r) begin exp_q.push_back(rexp); tag_q.push_back(tag); end
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; conv_strobe = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1, d, 0, 0, "", 0, 0, 0);
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    step(0, 0, 1, e, tag, 0, 0, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected rd_valid", 1, 0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<5000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 powered", powered, 0);
    chk("R1 ext_range", ext_range, 0);
    rd(8'h00, "R1 read cmd");
    step(0, 0, 0, 0, "", 2'b11, 7'h55, 7'h2A);
    wr(8'h43);
    rd(8'h00, "R8 ch0 untouched while down");
    wr(8'h1D);
    chk("R3 range ignored when down", ext_range, 0);
    wr(8'h03);
    chk("R2 powered", powered, 1);
    rd(8'h03, "R2 comm check");
    wr(8'h1D);
    chk("R3 ext set", ext_range, 1);
    rd(8'h1D, "R3 cmd reg");
    wr(8'h43);
    rd(8'h00, "R6 ch0 not yet valid");
    step(0, 0, 0, 0, "", 2'b01, 7'h2A, 0);
    rd(8'hAA, "R7 ch0 capture");
    wr(8'h03);
    chk("R4 range kept", ext_range, 1);
    wr(8'h83);
    chk("R4 range kept after select", ext_range, 1);
    step(0, 0, 0, 0, "", 2'b10, 0, 7'h00);
    rd(8'h80, "R7 below detection");
    step(0, 0, 0, 0, "", 2'b10, 0, 7'h7F);
    rd(8'hFF, "R7 overflow");
    wr(8'h55);
    chk("R9 powered kept", powered, 1);
    chk("R9 ext kept", ext_range, 1);
    rd(8'hFF, "R9 selection kept");
    wr(8'h18);
    chk("R3 ext cleared", ext_range, 0);
    rd(8'hFF, "R3 selection kept");
    wr(8'h43);
    step(0, 0, 0, 0, "", 2'b01, 7'h59, 0);
    rd(8'hD9, "R6 chord 5 step 9");
    step(0, 0, 1, 8'hD9, "R10 read before capture", 2'b01, 7'h12, 0);
    rd(8'h92, "R10 read after capture");
    wr(8'h1D);
    step(1, 8'h00, 0, 0, "", 2'b10, 0, 7'h33);
    chk("R5 powered cleared", powered, 0);
    chk("R5 ext cleared", ext_range, 0);
    rd(8'h00, "R5 cmd reg");
    wr(8'h83);
    rd(8'h7F, "R11 no capture, valid clear");
    wr(8'h43);
    rd(8'h12, "R5 ch0 data kept");
    wr(8'h03);
    chk("R4 standard after power cycle", ext_range, 0);
    step(1, 8'h43, 1, 8'h03, "R10 read before write", 0, 0, 0);
    rd(8'h12, "R6 select after write");
    repeat (3) @(posedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule